// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block sits on the receive side of a 32-bit configuration word stream. Each word arrives with a valid strobe. Until the synchronisation word is seen, the decoder discards everything. After that it treats each word as a packet header. A header may start a run of payload words that are written into a small register file. It may instead start a run of words that the block returns on an output stream.

There are two header forms. A short header names a target register and carries an 11-bit count. A long header carries a 27-bit count and reuses the target of the short header before it. The register file holds a frame address, a command register and a status word. Writes to the command register trigger actions: enter readback mode, clear the CRC error flag, or raise the global-high signal. Reads of the frame-data-out register return a modelled frame stream. Word k of such a read is the frame address plus k.

Top module: `cfg_pkt_decoder`

## Requirements
- R1: After reset, and until the word 0xAA995566 is taken with `in_valid` high, every word is discarded. `synced`, `out_valid`, `proto_err`, `rcfg_mode` and `ghigh` stay 0. `synced` goes to 1 on the cycle after the sync word is taken and stays 1 until reset.
- R2: A header whose opcode is 00 (bits [28:27]) has no effect. This includes 0x20000000. It changes no register and no output, and it does not disturb the target that a long header will reuse.
- R3: A short header has bits [31:29]=001, opcode 10 for write and 01 for read, target in bits [17:13] and count in bits [10:0]. A write with count n stores the next n valid words into the target. The frame address is at 1, frame-data-out at 3, command at 4 and status at 7. Reading address 1 returns the stored frame address.
- R4: A read header with nonzero count n drives `out_valid` high for exactly n consecutive cycles, starting the cycle after the header is taken.
- R5: The status word has bit 0 as the CRC error flag and bit 13 as the `rel_done_in` level. All other bits are 0. A pulse on `crc_err_in` sets bit 0. Writing command code 7 clears it. The code is taken from bits [4:0] of the command word.
- R6: Command code 4 sets `rcfg_mode`. Command code 8 sets `ghigh`. Both hold until reset.
- R7: A long header has bits [31:29]=010, the same opcode field and its count in bits [26:0]. It acts on the target of the most recent short read or write header. Each short header may be followed by at most one long header.
- R8: A long header taken when no short header has armed it pulses `proto_err` for one cycle and is otherwise ignored.
- R9: Reading frame-data-out returns, for output word k (counting from 0), the stored frame address plus k, modulo 2^32.
- R10: While output words are being delivered, input words are ignored. No header is decoded and no register is written until the count has been delivered.
- R11: A header with count 0 produces no payload and no output words. The next word is treated as a header. Words whose bits [31:29] are neither 001 nor 010, such as the all-zero flush word, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Configuration stream word |
| crc_err_in | input | 1 | Pulse that sets the CRC error flag |
| rel_done_in | input | 1 | Release-done level reported in status |
| synced | output | 1 | Sync word has been seen |
| out_valid | output | 1 | Read data word valid |
| out_word | output | 32 | Read data word |
| proto_err | output | 1 | One-cycle pulse for an unarmed long header |
| rcfg_mode | output | 1 | Readback mode requested |
| ghigh | output | 1 | Global-high requested |

## Verification
A wrong decoder state shows at the ports within one word. A missed or false sync changes `synced` on the following cycle. A wrong payload count shifts every later header, so the next register read returns a stale value or the next command action goes missing. A wrong readback counter shows as an output burst of the wrong length, or as words that break the frame-address-plus-index ramp. A wrong long-header arming flag shows as a burst where `proto_err` is expected, or the reverse, on the very next cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int SHORT_W = 11;
  localparam int CNT_W   = 27;
  localparam int CMD_W   = 5;
  localparam int STAT_CRC_BIT = 0;
  localparam int STAT_REL_BIT = 13;

  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA99_5566;

  localparam logic [ADDR_W-1:0] A_FAR  = 5'd1;
  localparam logic [ADDR_W-1:0] A_FDRO = 5'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd7;

  localparam logic [CMD_W-1:0] C_RCFG   = 5'd4;
  localparam logic [CMD_W-1:0] C_RCRC   = 5'd7;
  localparam logic [CMD_W-1:0] C_AGHIGH = 5'd8;

  typedef enum logic [1:0] {OP_NOP = 2'b00, OP_RD = 2'b01, OP_WR = 2'b10, OP_RSV = 2'b11} op_e;
  typedef enum logic [1:0] {S_HUNT, S_IDLE, S_WPAY, S_RDOUT} st_e;

  typedef struct packed {
    logic              t1;
    logic              t2;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
  } hdr_t;
endpackage

// File: rtl/cfgp_hdr_dec.sv
module cfgp_hdr_dec
  import cfgp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  always_comb begin
    hdr.t1   = (word[31:29] == 3'b001);
    hdr.t2   = (word[31:29] == 3'b010);
    hdr.op   = op_e'(word[28:27]);
    hdr.addr = word[17:13];
    if (word[31:29] == 3'b010) hdr.cnt = word[CNT_W-1:0];
    else hdr.cnt = {{(CNT_W-SHORT_W){1'b0}}, word[SHORT_W-1:0]};
  end
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              crc_set,
  input  logic              rel_done,
  output logic [WORD_W-1:0] far_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [WORD_W-1:0] stat,
  output logic              rcfg_q,
  output logic              ghigh_q
);
  logic             far_we, cmd_we;
  logic [CMD_W-1:0] code;
  logic             crc_q, crc_d, rcfg_d, ghigh_d;

  always_comb begin
    far_we  = wr_en && (wr_addr == A_FAR);
    cmd_we  = wr_en && (wr_addr == A_CMD);
    code    = wr_data[CMD_W-1:0];
    crc_d   = crc_q;
    rcfg_d  = rcfg_q;
    ghigh_d = ghigh_q;
    if (cmd_we && code == C_RCRC)   crc_d   = 1'b0;
    if (crc_set)                    crc_d   = 1'b1;
    if (cmd_we && code == C_RCFG)   rcfg_d  = 1'b1;
    if (cmd_we && code == C_AGHIGH) ghigh_d = 1'b1;
  end

  always_comb begin
    stat = '0;
    stat[STAT_CRC_BIT] = crc_q;
    stat[STAT_REL_BIT] = rel_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_q   <= '0;
      cmd_q   <= '0;
      crc_q   <= 1'b0;
      rcfg_q  <= 1'b0;
      ghigh_q <= 1'b0;
    end else begin
      if (far_we) far_q <= wr_data;
      if (cmd_we) cmd_q <= code;
      crc_q   <= crc_d;
      rcfg_q  <= rcfg_d;
      ghigh_q <= ghigh_d;
    end
  end

  // R5: a clear command without a concurrent set leaves the flag low
  a_r5_rcrc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && code == C_RCRC && !crc_set) |=> !stat[STAT_CRC_BIT]);
  // R5: a set pulse always raises the flag
  a_r5_crc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    crc_set |=> stat[STAT_CRC_BIT]);
  // R6: command effects are sticky
  a_r6_ghigh_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ghigh_q |=> ghigh_q);
  a_r6_rcfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rcfg_q |=> rcfg_q);
endmodule

// File: rtl/cfgp_rdout.sv
module cfgp_rdout
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] far_q,
  input  logic [CMD_W-1:0]  cmd_q,
  input  logic [WORD_W-1:0] stat,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              last
);
  logic [CNT_W-1:0]  rem_q, rem_d, idx_q, idx_d;
  logic [ADDR_W-1:0] tgt_q;
  logic              busy;

  assign busy      = (rem_q != '0);
  assign out_valid = busy;
  assign last      = (rem_q == CNT_W'(1));

  always_comb begin
    rem_d = rem_q;
    idx_d = idx_q;
    if (start) begin
      rem_d = cnt;
      idx_d = '0;
    end else if (busy) begin
      rem_d = rem_q - CNT_W'(1);
      idx_d = idx_q + CNT_W'(1);
    end
  end

  always_comb begin
    out_word = '0;
    if (busy) begin
      unique case (tgt_q)
        A_FDRO:  out_word = far_q + {{(WORD_W-CNT_W){1'b0}}, idx_q};
        A_FAR:   out_word = far_q;
        A_CMD:   out_word = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
        A_STAT:  out_word = stat;
        default: out_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
      tgt_q <= '0;
    end else begin
      rem_q <= rem_d;
      idx_q <= idx_d;
      if (start) tgt_q <= addr;
    end
  end

  // R9: consecutive frame words step by one
  a_r9_fdro_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && tgt_q == A_FDRO && !$past(start))
      |-> out_word == $past(out_word) + 32'd1);
  // R4: a burst is never restarted while one is running
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/cfg_pkt_decoder.sv
module cfg_pkt_decoder
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic        crc_err_in,
  input  logic        rel_done_in,
  output logic        synced,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic        proto_err,
  output logic        rcfg_mode,
  output logic        ghigh
);
  st_e               st_q, st_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d, addr_eff;
  logic              arm_q, arm_d;
  logic [CNT_W-1:0]  wrem_q, wrem_d;
  logic              perr_q, perr_d;
  logic              hdr_go, rd_start, wr_en, rd_last;
  hdr_t              hdr;
  logic [WORD_W-1:0] far_q, stat;
  logic [CMD_W-1:0]  cmd_q;

  cfgp_hdr_dec u_dec (.word(in_word), .hdr(hdr));

  cfgp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(tgt_q), .wr_data(in_word),
    .crc_set(crc_err_in), .rel_done(rel_done_in), .far_q(far_q), .cmd_q(cmd_q),
    .stat(stat), .rcfg_q(rcfg_mode), .ghigh_q(ghigh)
  );

  cfgp_rdout u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .cnt(hdr.cnt), .addr(addr_eff),
    .far_q(far_q), .cmd_q(cmd_q), .stat(stat), .out_valid(out_valid),
    .out_word(out_word), .last(rd_last)
  );

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    arm_d    = arm_q;
    wrem_d   = wrem_q;
    perr_d   = 1'b0;
    rd_start = 1'b0;
    wr_en    = 1'b0;
    addr_eff = hdr.t1 ? hdr.addr : tgt_q;
    hdr_go   = (hdr.t1 || (hdr.t2 && arm_q)) && (hdr.op == OP_RD || hdr.op == OP_WR);
    unique case (st_q)
      S_HUNT: if (in_valid && in_word == SYNC_WORD) st_d = S_IDLE;
      S_IDLE: if (in_valid) begin
        if (hdr.t2 && !arm_q) perr_d = 1'b1;
        if (hdr_go) begin
          tgt_d = addr_eff;
          arm_d = hdr.t1;
          if (hdr.cnt != '0) begin
            if (hdr.op == OP_RD) begin
              rd_start = 1'b1;
              st_d     = S_RDOUT;
            end else begin
              wrem_d = hdr.cnt;
              st_d   = S_WPAY;
            end
          end
        end
      end
      S_WPAY: if (in_valid) begin
        wr_en  = 1'b1;
        wrem_d = wrem_q - CNT_W'(1);
        if (wrem_q == CNT_W'(1)) st_d = S_IDLE;
      end
      S_RDOUT: if (rd_last) st_d = S_IDLE;
      default: st_d = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_HUNT;
      tgt_q  <= '0;
      arm_q  <= 1'b0;
      wrem_q <= '0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      perr_q <= perr_d;
      if (st_q == S_IDLE) begin
        tgt_q <= tgt_d;
        arm_q <= arm_d;
      end
      if (st_q != S_HUNT) wrem_q <= wrem_d;
    end
  end

  assign synced    = (st_q != S_HUNT);
  assign proto_err = perr_q;

  // R1: nothing leaves the block before sync
  a_r1_quiet_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!out_valid && !proto_err && !rcfg_mode && !ghigh));
  // R1: sync is entered only on the sync word
  a_r1_sync_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> ($past(in_valid) && $past(in_word) == SYNC_WORD));
  // R1: sync is never lost
  a_r1_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);
  // R8: a rejected header starts no burst
  a_r8_err_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !out_valid);
  // R10: input during a burst writes nothing
  a_r10_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_valid) |=> ($stable(far_q) && $stable(cmd_q) && $stable(ghigh)));
endmodule

// File: tb/cfg_pkt_decoder_bench.sv
module cfg_pkt_decoder_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n, in_valid, crc_err_in, rel_done_in;
  logic [31:0] in_word;
  logic        synced, out_valid, proto_err, rcfg_mode, ghigh;
  logic [31:0] out_word;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cfg_pkt_decoder u_cfg_pkt_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .crc_err_in(crc_err_in), .rel_done_in(rel_done_in), .synced(synced),
    .out_valid(out_valid), .out_word(out_word), .proto_err(proto_err),
    .rcfg_mode(rcfg_mode), .ghigh(ghigh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = '0;
  endtask

  function automatic logic [31:0] junk(input int k);
    case (k % 4)
      0: junk = 32'h3000_2001;
      1: junk = 32'hDEAD_BEEF;
      2: junk = 32'h3000_8001;
      default: junk = 32'h0000_0008;
    endcase
  endfunction

  task automatic drain(input string req, input int n, input logic [31:0] base,
                       input bit inc, input bit inject);
    for (int k = 0; k < n; k++) begin
      chk(req, {31'b0, out_valid}, 32'd1);
      chk(req, out_word, inc ? base + 32'(k) : base);
      if (inject) begin
        in_valid = 1'b1;
        in_word  = junk(k);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_word  = '0;
    chk(req, {31'b0, out_valid}, 32'd0);
  endtask

  task automatic read_far(input string req, input logic [31:0] exp);
    push(32'h2800_2001);
    drain(req, 1, exp, 1'b0, 1'b0);
  endtask

  task automatic write_far(input logic [31:0] v);
    push(32'h3000_2001);
    push(v);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; crc_err_in = 1'b0; rel_done_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset", {27'b0, synced, out_valid, proto_err, rcfg_mode, ghigh}, 32'd0);

    // R1: words before sync are discarded
    push(32'hFFFF_FFFF);
    push(32'h3000_8001);
    push(32'h0000_0008);
    push(32'h2800_E001);
    chk("R1 pre-sync", {27'b0, synced, out_valid, proto_err, rcfg_mode, ghigh}, 32'd0);
    push(32'h4800_0002);
    chk("R1 pre-sync long", {30'b0, out_valid, proto_err}, 32'd0);
    push(32'hAA99_5566);
    chk("R1 synced", {31'b0, synced}, 32'd1);

    // R8: unarmed long header
    push(32'h4800_0002);
    chk("R8 perr", {31'b0, proto_err}, 32'd1);
    chk("R8 no burst", {31'b0, out_valid}, 32'd0);
    push(32'h0000_0000);
    chk("R8 pulse width", {30'b0, proto_err, out_valid}, 32'd0);

    // R5: status word sweep
    for (int rd = 0; rd < 2; rd++) begin
      rel_done_in = rd[0];
      push(32'h2800_E001);
      drain("R5 stat clean", 1, {18'b0, rd[0], 13'b0}, 1'b0, 1'b0);
      crc_err_in = 1'b1;
      @(negedge clk);
      crc_err_in = 1'b0;
      push(32'h2800_E001);
      drain("R5 stat crc", 1, {18'b0, rd[0], 12'b0, 1'b1}, 1'b0, 1'b0);
      push(32'h3000_8001);
      push(32'h0000_0007);
      push(32'h2800_E001);
      drain("R5 rcrc clear", 1, {18'b0, rd[0], 13'b0}, 1'b0, 1'b0);
    end
    rel_done_in = 1'b0;

    // R3 R2 R4 R9 R7 R11: address sweep with short and long read headers
    for (int i = 0; i < 6; i++) begin
      logic [31:0] fa;
      fa = (32'(i) * 32'h0101_0101) ^ 32'h5A5A_0000;
      if (i == 5) fa = 32'hFFFF_FFFE;
      write_far(fa);
      push(32'h2000_0000);
      push(32'h0000_0000);
      read_far("R3 far readback", fa);
      for (int n = 1; n <= 4; n++) begin
        push(32'h2800_6000 | 32'(n));
        drain("R4 R9 short burst", n, fa, 1'b1, 1'b0);
      end
      for (int m = 0; m <= 5; m++) begin
        push(32'h2800_6000);
        push(32'h2000_0000);
        push(32'h4800_0000 | 32'(m));
        chk("R7 R2 no perr", {31'b0, proto_err}, 32'd0);
        drain("R7 R11 long burst", m, fa, 1'b1, 1'b0);
      end
    end

    // R7: long write reuses the short header target
    push(32'h3000_2000);
    push(32'h5000_0003);
    push(32'h1111_1111);
    push(32'h2222_2222);
    push(32'h3333_3333);
    read_far("R7 long write", 32'h3333_3333);

    // R8: a second long header is not armed
    push(32'h2800_6000);
    push(32'h4800_0001);
    drain("R7 single", 1, 32'h3333_3333, 1'b1, 1'b0);
    push(32'h4800_0001);
    chk("R8 rearm", {30'b0, proto_err, out_valid}, 32'd2);

    // R10: input during a burst is ignored
    write_far(32'h0000_0100);
    push(32'h2800_6004);
    drain("R10 burst", 4, 32'h0000_0100, 1'b1, 1'b1);
    chk("R10 ghigh", {31'b0, ghigh}, 32'd0);
    read_far("R10 far kept", 32'h0000_0100);

    // R11: zero-count write, then a non-header word
    push(32'h3000_8000);
    push(32'h0000_0008);
    chk("R11 zero count", {30'b0, rcfg_mode, ghigh}, 32'd0);
    read_far("R11 far kept", 32'h0000_0100);

    // R6: command actions
    push(32'h3000_8001);
    push(32'h0000_0004);
    chk("R6 rcfg", {30'b0, rcfg_mode, ghigh}, 32'd2);
    push(32'h3000_8001);
    push(32'h0000_0008);
    chk("R6 ghigh", {30'b0, rcfg_mode, ghigh}, 32'd3);
    push(32'h3000_8001);
    push(32'h0000_0007);
    chk("R6 sticky", {30'b0, rcfg_mode, ghigh}, 32'd3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule